// File: doc/BRIEF.md
# TLB Fault Capture and Refill-Set Selector

This block sits beside an address-translation lookup and records what a page-table handler needs whenever a lookup faults. On each fault it fills two packed registers in one clock. The selector register tells the handler which TLB slot to write. The cause register holds the faulting page, the process identifier and the kind of access.

A 16-bit right-shifting pseudo-random register picks the replacement set on a miss. It uses fixed feedback taps and moves one step on every fault. It never moves on a successful lookup. On a protection fault the set that matched is reported instead. The lookup itself, the TLB storage and the handler are outside this block.

The reset is asynchronous and active low. Its release is synchronised inside the block, so the registers leave their reset values two clock edges after the reset input rises.

Top module: `tlb_fault_capture`

## Requirements
- R1: While reset is active, and after it is released, `rnd_o` reads 0xCCCC and `sel_o` and `cause_o` read zero until the first fault.
- R2: On each clock edge with `fault_i` high, the random register becomes {p, old[15:1]}. Here p is the XOR of all bits of (old AND 0x8805), so the feedback bit enters at bit 15.
- R3: With `fault_i` low, `rnd_o`, `sel_o` and `cause_o` keep their values whatever the other inputs do.
- R4: On a fault with `miss_i` high, the set number in `sel_o` bits 5:4 equals bits 1:0 of the random register as it was before that same fault advanced it.
- R5: On a fault with `miss_i` low (a protection fault), `sel_o` bits 5:4 equal `hit_set_i`.
- R6: After a fault, `sel_o` bits 3:0 hold `vpn_i` bits 3:0, and `sel_o` bits 31:6 are zero.
- R7: After a fault, `cause_o` holds `pid_i` in bits 7:0, `kind_i` in bits 9:8 and `vpn_i` in bits 31:13. The access-kind code is 0 for read, 1 for write and 2 for execute.
- R8: `cause_o` bits 12:10 keep their previous value across a fault update, so they stay zero from reset.
- R9: All three outputs take their new values at the clock edge that samples `fault_i` high, and are visible in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_i | input | 1 | Lookup faulted this cycle |
| miss_i | input | 1 | 1 = no matching entry, 0 = protection failure |
| hit_set_i | input | 2 | Matching set on a protection failure |
| vpn_i | input | 19 | Virtual page number of the access |
| pid_i | input | 8 | Current process identifier |
| kind_i | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| sel_o | output | 32 | Slot selector register (index 3:0, set 5:4) |
| cause_o | output | 32 | Fault cause register |
| rnd_o | output | 16 | Current random register state |

## Verification
The vector walk interleaves misses and protection faults that carry distinct page numbers, process identifiers and kinds. This shows whether the reported set comes from the random register's pre-advance low bits or from the matched set. Idle vectors whose inputs change between faults show that nothing moves without a fault. A long run of back-to-back misses follows the random sequence step by step, so a wrong tap or a wrong shift direction shows up. A reset in the middle of a run confirms that the seed and the zeroed registers return.

// File: rtl/tlbf_pkg.sv
package tlbf_pkg;
  localparam int RND_W      = 16;
  localparam int REG_W      = 32;
  localparam int VPN_W      = 19;
  localparam int PID_W      = 8;
  localparam int KIND_W     = 2;
  localparam int IDX_W      = 4;
  localparam int SET_W      = 2;
  localparam int SEL_IDX_LSB = 0;
  localparam int SEL_SET_LSB = SEL_IDX_LSB + IDX_W;
  localparam int CAU_PID_LSB = 0;
  localparam int CAU_KND_LSB = CAU_PID_LSB + PID_W;
  localparam int CAU_VPN_LSB = REG_W - VPN_W;

  typedef enum logic [KIND_W-1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/tlbf_rst_sync.sv
module tlbf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/tlbf_lfsr.sv
module tlbf_lfsr #(
  parameter int             W    = 16,
  parameter logic [W-1:0]   SEED = 16'hCCCC,
  parameter logic [W-1:0]   TAPS = 16'h8805
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_i,
  output logic [W-1:0] state_o
);
  logic [W-1:0] state_q, state_d;
  logic         fb;

  always_comb begin
    fb      = ^(state_q & TAPS);
    state_d = {fb, state_q[W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      state_q <= SEED;
    else if (step_i) state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/tlbf_sel_reg.sv
module tlbf_sel_reg
  import tlbf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [SET_W-1:0] set_i,
  output logic [REG_W-1:0] sel_o
);
  logic [REG_W-1:0] sel_q, sel_d;

  always_comb begin
    sel_d = '0;
    sel_d[SEL_IDX_LSB +: IDX_W] = idx_i;
    sel_d[SEL_SET_LSB +: SET_W] = set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= '0;
    else if (load_i) sel_q <= sel_d;
  end

  assign sel_o = sel_q;
endmodule

// File: rtl/tlbf_cause_reg.sv
module tlbf_cause_reg
  import tlbf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [PID_W-1:0]  pid_i,
  input  logic [KIND_W-1:0] kind_i,
  input  logic [VPN_W-1:0]  vpn_i,
  output logic [REG_W-1:0]  cause_o
);
  logic [REG_W-1:0] cause_q, cause_d;

  always_comb begin
    cause_d = cause_q;
    cause_d[CAU_PID_LSB +: PID_W]  = pid_i;
    cause_d[CAU_KND_LSB +: KIND_W] = kind_i;
    cause_d[CAU_VPN_LSB +: VPN_W]  = vpn_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cause_q <= '0;
    else if (load_i) cause_q <= cause_d;
  end

  assign cause_o = cause_q;
endmodule

// File: rtl/tlb_fault_capture.sv
module tlb_fault_capture
  import tlbf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fault_i,
  input  logic              miss_i,
  input  logic [SET_W-1:0]  hit_set_i,
  input  logic [VPN_W-1:0]  vpn_i,
  input  logic [PID_W-1:0]  pid_i,
  input  logic [KIND_W-1:0] kind_i,
  output logic [REG_W-1:0]  sel_o,
  output logic [REG_W-1:0]  cause_o,
  output logic [RND_W-1:0]  rnd_o
);
  logic             rst_sync_n;
  logic [RND_W-1:0] rnd;
  logic [SET_W-1:0] set_pick;

  tlbf_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  tlbf_lfsr #(.W(RND_W), .SEED(16'hCCCC), .TAPS(16'h8805)) u_rnd (
    .clk(clk), .rst_n(rst_sync_n), .step_i(fault_i), .state_o(rnd)
  );

  always_comb begin
    set_pick = miss_i ? rnd[SET_W-1:0] : hit_set_i;
  end

  tlbf_sel_reg u_sel (
    .clk(clk), .rst_n(rst_sync_n), .load_i(fault_i),
    .idx_i(vpn_i[IDX_W-1:0]), .set_i(set_pick), .sel_o(sel_o)
  );

  tlbf_cause_reg u_cause (
    .clk(clk), .rst_n(rst_sync_n), .load_i(fault_i),
    .pid_i(pid_i), .kind_i(kind_i), .vpn_i(vpn_i), .cause_o(cause_o)
  );

  assign rnd_o = rnd;
endmodule

// File: rtl/tlbf_checker.sv
module tlbf_checker (
  input logic        clk,
  input logic        rst_sync_n,
  input logic        fault_i,
  input logic        miss_i,
  input logic [1:0]  hit_set_i,
  input logic [18:0] vpn_i,
  input logic [7:0]  pid_i,
  input logic [1:0]  kind_i,
  input logic [31:0] sel_o,
  input logic [31:0] cause_o,
  input logic [15:0] rnd_o
);
  a_r2_rnd_step: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fault_i |=> rnd_o == {^($past(rnd_o) & 16'h8805), $past(rnd_o[15:1])});

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !fault_i |=> $stable(rnd_o) && $stable(sel_o) && $stable(cause_o));

  a_r4_miss_set: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fault_i && miss_i |=> sel_o[5:4] == $past(rnd_o[1:0]));

  a_r5_prot_set: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fault_i && !miss_i |=> sel_o[5:4] == $past(hit_set_i));

  a_r6_sel_layout: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fault_i |=> sel_o[3:0] == $past(vpn_i[3:0]) && sel_o[31:6] == 26'd0);

  a_r7_cause_fields: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fault_i |=> cause_o[7:0] == $past(pid_i) && cause_o[9:8] == $past(kind_i)
                && cause_o[31:13] == $past(vpn_i));

  a_r8_cause_gap: assert property (@(posedge clk) disable iff (!rst_sync_n)
    1'b1 |=> $stable(cause_o[12:10]));
endmodule

bind tlb_fault_capture tlbf_checker u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .fault_i(fault_i), .miss_i(miss_i),
  .hit_set_i(hit_set_i), .vpn_i(vpn_i), .pid_i(pid_i), .kind_i(kind_i),
  .sel_o(sel_o), .cause_o(cause_o), .rnd_o(rnd_o)
);

// File: tb/tb_tlb_fault_capture.sv
module tb_tlb_fault_capture;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        fault_i, miss_i;
  logic [1:0]  hit_set_i, kind_i;
  logic [18:0] vpn_i;
  logic [7:0]  pid_i;
  logic [31:0] sel_o, cause_o;
  logic [15:0] rnd_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] m_rnd;
  logic [31:0] m_sel, m_cause;

  always #2 clk = ~clk;

  tlb_fault_capture dut (
    .clk(clk), .rst_n(rst_n), .fault_i(fault_i), .miss_i(miss_i),
    .hit_set_i(hit_set_i), .vpn_i(vpn_i), .pid_i(pid_i), .kind_i(kind_i),
    .sel_o(sel_o), .cause_o(cause_o), .rnd_o(rnd_o)
  );

  // {fault, miss, hit_set, kind, pid, vpn}
  localparam int NV = 10;
  localparam logic [32:0] VEC [NV] = '{
    {1'b1, 1'b1, 2'd0, 2'd0, 8'h11, 19'h12345},
    {1'b1, 1'b0, 2'd3, 2'd1, 8'h22, 19'h00ABC},
    {1'b0, 1'b1, 2'd2, 2'd2, 8'hFF, 19'h7FFFF},
    {1'b1, 1'b1, 2'd1, 2'd2, 8'h5A, 19'h4000F},
    {1'b1, 1'b0, 2'd2, 2'd0, 8'h00, 19'h00001},
    {1'b0, 1'b0, 2'd1, 2'd1, 8'h33, 19'h11111},
    {1'b1, 1'b1, 2'd3, 2'd1, 8'hA5, 19'h2AAAA},
    {1'b1, 1'b1, 2'd0, 2'd0, 8'h7E, 19'h55555},
    {1'b1, 1'b0, 2'd1, 2'd2, 8'hC3, 19'h3C3C7},
    {1'b1, 1'b1, 2'd2, 2'd0, 8'h01, 19'h7FFF8}
  };

  task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Bench model of one clock edge with the given stimulus (R2, R4..R8).
  task automatic model_edge(input logic f, input logic m, input logic [1:0] hs,
                            input logic [1:0] k, input logic [7:0] p, input logic [18:0] v);
    logic [1:0] s;
    if (f) begin
      s = m ? m_rnd[1:0] : hs;
      m_sel   = {26'd0, s, v[3:0]};
      m_cause = {v, m_cause[12:10], k, p};
      m_rnd   = {^(m_rnd & 16'h8805), m_rnd[15:1]};
    end
  endtask

  task automatic apply(input logic f, input logic m, input logic [1:0] hs,
                       input logic [1:0] k, input logic [7:0] p, input logic [18:0] v);
    @(negedge clk);
    fault_i = f; miss_i = m; hit_set_i = hs; kind_i = k; pid_i = p; vpn_i = v;
    @(posedge clk);
    model_edge(f, m, hs, k, p, v);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; fault_i = 1'b0; miss_i = 1'b0; hit_set_i = '0;
    kind_i = '0; pid_i = '0; vpn_i = '0;
    m_rnd = 16'hCCCC; m_sel = '0; m_cause = '0;
    repeat (3) @(negedge clk);
    check32("R1 rnd in reset", {16'd0, rnd_o}, 32'h0000CCCC);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #20000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    check32("R1 rnd after reset", {16'd0, rnd_o}, 32'h0000CCCC);
    check32("R1 sel after reset", sel_o, 32'd0);
    check32("R1 cause after reset", cause_o, 32'd0);

    // Vector walk: R2 R3 R4 R5 R6 R7 R8 R9
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][32], VEC[i][31], VEC[i][30:29], VEC[i][28:27],
            VEC[i][26:19], VEC[i][18:0]);
      check32("R2/R9 rnd", {16'd0, rnd_o}, {16'd0, m_rnd});
      check32("R4/R5/R6 sel", sel_o, m_sel);
      check32("R7/R8 cause", cause_o, m_cause);
    end

    // R3: idle cycles with churning inputs
    for (int i = 0; i < 6; i++) begin
      apply(1'b0, i[0], i[1:0], i[2:1], 8'(i * 37), 19'(i * 9001));
      check32("R3 rnd hold", {16'd0, rnd_o}, {16'd0, m_rnd});
      check32("R3 sel hold", sel_o, m_sel);
      check32("R3 cause hold", cause_o, m_cause);
    end

    // R2, R4: long back-to-back miss run tracking the sequence
    for (int i = 0; i < 40; i++) begin
      apply(1'b1, 1'b1, 2'd0, 2'd2, 8'(i), 19'(i * 3));
      check32("R2 rnd sequence", {16'd0, rnd_o}, {16'd0, m_rnd});
      check32("R4 miss set", sel_o, m_sel);
    end

    // R8: cause gap bits remain zero
    check32("R8 cause 12:10", {29'd0, cause_o[12:10]}, 32'd0);

    // R1: reset mid-run restores seed and clears registers
    do_reset();
    check32("R1 rnd after mid-run reset", {16'd0, rnd_o}, 32'h0000CCCC);
    check32("R1 sel after mid-run reset", sel_o, 32'd0);
    check32("R1 cause after mid-run reset", cause_o, 32'd0);

    // R4 R9: first miss after reset uses seed low bits (0xCCCC -> set 0)
    apply(1'b1, 1'b1, 2'd3, 2'd1, 8'h9C, 19'h0000B);
    check32("R4 first miss set from seed", sel_o, 32'h0000000B);
    check32("R9 rnd first step", {16'd0, rnd_o}, {16'd0, m_rnd});

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule